// File: doc/BRIEF.md
# Protected Watchdog Timer

This block is a watchdog that counts ticks from a separate slow oscillator. The tick arrives as a one-cycle strobe in the system clock domain. Software keeps it quiet by pulsing a restart strobe. If the restart does not come in time, the watchdog times out. It then emits a one-cycle reset pulse, raises an interrupt request, or does both in sequence: an interrupt first, and a reset on the next timeout unless software re-arms the interrupt.

The timeout length is picked by a 4-bit period code. The reset enable and the period code are guarded by a timed unlock. A first write opens a short window, and only a write that lands inside that window may change them. A safety input forces the watchdog on. The period code can still change only through the unlock sequence.

The control register is 8 bits wide and is read back on a dedicated output. Its bit positions are fixed:

| Bit | Meaning |
|-----|---------|
| 7 | timeout flag (write 1 to clear) |
| 6 | interrupt enable |
| 5 | period code bit 3 |
| 4 | unlock window open (read-only) |
| 3 | reset enable |
| 2:0 | period code bits 2:0 |

Top module: `wdt_guard`

## Requirements
- R1: After synchronous reset, the control register reads 0x00 (bit 3 reads 1 if `safety_on` is high), `rst_pulse` is low and `irq` is low.
- R2: In reset mode (bit 3 = 1, bit 6 = 0), each timeout produces a `rst_pulse` exactly one cycle wide. Consecutive pulses are spaced 2^(BASE_LOG2+p) ticks apart, where p = {bit5, bits2:0}.
- R3: In interrupt mode (bit 6 = 1, bit 3 = 0), a timeout sets bit 7 and drives `irq` high without any reset pulse, and bit 6 stays set. Writing 1 to bit 7 clears the flag.
- R4: In combined mode (bits 6 and 3 both set), a timeout sets bit 7 and clears bit 6 with no reset pulse. If software sets bit 6 again, the next timeout is again an interrupt; otherwise the next timeout emits `rst_pulse`.
- R5: A write with bits 4 and 3 both set opens the unlock window, and bit 4 then reads 1. The next write, if it comes within 4 cycles, loads bit 3 and the period code from its data and closes the window.
- R6: A write made while the window is closed leaves bit 3 and the period code unchanged. Bits 6 and 7 are still written normally.
- R7: If no write arrives within 4 cycles of opening, bit 4 clears by itself, and a later write cannot change bit 3 or the period code.
- R8: While `safety_on` is high, bit 3 reads 1 and timeouts act as if reset enable were set. The period code still changes only through the unlock sequence.
- R9: Period codes 10 to 15 give the same timeout as code 9.
- R10: A `restart` strobe clears the tick count, so the next timeout falls a full period after the strobe. The control register is not changed by it.
- R11: The count advances only on cycles where `tick` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle strobe from the slow oscillator |
| restart | input | 1 | Restart strobe that clears the tick count |
| safety_on | input | 1 | Forces the watchdog always on |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write data |
| ctrl_rd | output | 8 | Control register read value |
| rst_pulse | output | 1 | One-cycle reset request |
| irq | output | 1 | Interrupt request (level, follows the timeout flag) |

## Verification
A wrong count in the tick counter shows up as a pulse spacing that differs from 2^(BASE_LOG2+p). The error is visible on the first full period after the fault, so the bench measures the exact cycle distance between events. A stuck or mistimed unlock window shows in bit 4 of the read value within five cycles of the opening write. It also shows as a period code or reset enable that changes when it should not. A wrong mode decision shows at the very next timeout, either as an unexpected reset pulse or as a missing flag.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef struct packed {
        logic       flag;
        logic       irq_en;
        logic       per_hi;
        logic       win;
        logic       rst_en;
        logic [2:0] per_lo;
    } wdt_ctrl_t;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_RESET = 2'd1,
        MODE_IRQ   = 2'd2,
        MODE_BOTH  = 2'd3
    } wdt_mode_e;

    localparam int PER_MAX = 9;

    function automatic logic [3:0] clamp_per(input logic [3:0] p);
        return (p > 4'(PER_MAX)) ? 4'(PER_MAX) : p;
    endfunction

    function automatic wdt_mode_e pick_mode(input logic irq_en, input logic rst_on);
        return wdt_mode_e'({irq_en, rst_on});
    endfunction

endpackage

// File: rtl/wdt_unlock.sv
module wdt_unlock #(
    parameter int WIN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic wr_win,
    input  logic wr_rst_en,
    output logic win_open,
    output logic apply_ok
);
    localparam int CW = $clog2(WIN + 1);

    logic [CW-1:0] left_q;

    assign apply_ok = wr_en && win_open;

    always_ff @(posedge clk) begin
        if (rst) begin
            win_open <= 1'b0;
            left_q   <= '0;
        end else if (win_open) begin
            if (wr_en || left_q == CW'(1)) begin
                win_open <= 1'b0;
                left_q   <= '0;
            end else begin
                left_q <= left_q - CW'(1);
            end
        end else if (wr_en && wr_win && wr_rst_en) begin
            win_open <= 1'b1;
            left_q   <= CW'(WIN);
        end
    end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
#(
    parameter int BASE_LOG2 = 11
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       tick,
    input  logic       restart,
    input  logic [3:0] per,
    output logic       timeout
);
    localparam int CW = BASE_LOG2 + PER_MAX;

    logic [CW-1:0] cnt_q;
    logic [CW:0]   span;
    logic [CW-1:0] last;
    logic [3:0]    per_c;

    always_comb begin
        per_c = clamp_per(per);
        span  = {{CW{1'b0}}, 1'b1} << (BASE_LOG2 + int'(per_c));
        last  = CW'(span - (CW + 1)'(1));
    end

    assign timeout = run && tick && !restart && (cnt_q >= last);

    always_ff @(posedge clk) begin
        if (rst || !run || restart) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= (cnt_q >= last) ? '0 : cnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       safety_on,
    input  logic       wr_en,
    input  wdt_ctrl_t  wr_val,
    input  logic       apply_ok,
    input  logic       win_open,
    input  logic       timeout,
    output wdt_ctrl_t  view,
    output logic [3:0] per,
    output logic       run,
    output logic       rst_pulse
);
    logic       flag_q;
    logic       irq_en_q;
    logic       rst_en_q;
    logic [3:0] per_q;
    logic       rst_on;
    wdt_mode_e  mode;

    assign rst_on = rst_en_q || safety_on;
    assign mode   = pick_mode(irq_en_q, rst_on);
    assign run    = (mode != MODE_OFF);
    assign per    = per_q;

    always_comb begin
        view.flag   = flag_q;
        view.irq_en = irq_en_q;
        view.per_hi = per_q[3];
        view.win    = win_open;
        view.rst_en = rst_on;
        view.per_lo = per_q[2:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q    <= 1'b0;
            irq_en_q  <= 1'b0;
            rst_en_q  <= 1'b0;
            per_q     <= '0;
            rst_pulse <= 1'b0;
        end else begin
            rst_pulse <= 1'b0;
            if (wr_en) begin
                irq_en_q <= wr_val.irq_en;
                if (wr_val.flag) flag_q <= 1'b0;
            end
            if (apply_ok) begin
                rst_en_q <= wr_val.rst_en;
                per_q    <= {wr_val.per_hi, wr_val.per_lo};
            end
            if (timeout) begin
                unique case (mode)
                    MODE_IRQ:   flag_q <= 1'b1;
                    MODE_BOTH: begin
                        flag_q   <= 1'b1;
                        irq_en_q <= 1'b0;
                    end
                    MODE_RESET: rst_pulse <= 1'b1;
                    default:    ;
                endcase
            end
        end
    end
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
    import wdt_pkg::*;
#(
    parameter int BASE_LOG2 = 11,
    parameter int WIN       = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       restart,
    input  logic       safety_on,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] ctrl_rd,
    output logic       rst_pulse,
    output logic       irq
);
    wdt_ctrl_t  wr_val;
    wdt_ctrl_t  view;
    logic       win_open;
    logic       apply_ok;
    logic       timeout;
    logic       run;
    logic [3:0] per;

    assign wr_val  = wdt_ctrl_t'(wr_data);
    assign ctrl_rd = view;
    assign irq     = view.flag;

    wdt_unlock #(.WIN(WIN)) u_unlock (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_win   (wr_val.win),
        .wr_rst_en(wr_val.rst_en),
        .win_open (win_open),
        .apply_ok (apply_ok)
    );

    wdt_counter #(.BASE_LOG2(BASE_LOG2)) u_counter (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .tick   (tick),
        .restart(restart),
        .per    (per),
        .timeout(timeout)
    );

    wdt_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .safety_on(safety_on),
        .wr_en    (wr_en),
        .wr_val   (wr_val),
        .apply_ok (apply_ok),
        .win_open (win_open),
        .timeout  (timeout),
        .view     (view),
        .per      (per),
        .run      (run),
        .rst_pulse(rst_pulse)
    );
endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk #(
    parameter int WIN = 4
) (
    input logic       clk,
    input logic       rst,
    input logic       safety_on,
    input logic [7:0] ctrl_rd,
    input logic       rst_pulse,
    input logic       irq
);
    logic [7:0] open_run;

    always_ff @(posedge clk) begin
        if (rst) open_run <= '0;
        else if (!ctrl_rd[4]) open_run <= '0;
        else if (open_run != 8'hFF) open_run <= open_run + 8'd1;
    end

    // R2
    pulse_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        rst_pulse |=> !rst_pulse);

    // R4
    pulse_needs_irq_off_chk: assert property (@(posedge clk) disable iff (rst)
        rst_pulse |-> !$past(ctrl_rd[6]));

    // R3
    irq_without_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> !rst_pulse);

    // R6
    period_locked_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(ctrl_rd[4]) |-> $stable({ctrl_rd[5], ctrl_rd[2:0]}));

    // R7
    window_len_chk: assert property (@(posedge clk) disable iff (rst)
        open_run <= 8'(WIN));

    // R8
    safety_reads_on_chk: assert property (@(posedge clk) disable iff (rst)
        safety_on |-> ctrl_rd[3]);

    // R8
    pulse_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        rst_pulse |-> $past(ctrl_rd[3]));
endmodule

bind wdt_guard wdt_guard_chk #(.WIN(WIN)) u_guard_chk (
    .clk      (clk),
    .rst      (rst),
    .safety_on(safety_on),
    .ctrl_rd  (ctrl_rd),
    .rst_pulse(rst_pulse),
    .irq      (irq)
);

// File: tb/wdt_guard_bench.sv
module wdt_guard_bench;
    localparam int B = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b1;
    logic       restart = 1'b0;
    logic       safety_on = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] ctrl_rd;
    logic       rst_pulse;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    wdt_guard #(.BASE_LOG2(B), .WIN(4)) u_wdt_guard (
        .clk(clk), .rst(rst), .tick(tick), .restart(restart),
        .safety_on(safety_on), .wr_en(wr_en), .wr_data(wr_data),
        .ctrl_rd(ctrl_rd), .rst_pulse(rst_pulse), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    task automatic unlock(input logic [7:0] d);
        wr(8'h18);
        wr(d);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // cycles until rst_pulse is seen, -1 if not within maxc
    task automatic wait_pulse(input int maxc, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!rst_pulse && n < maxc);
        if (!rst_pulse) n = -1;
    endtask

    task automatic wait_irq(input int maxc, output int n, output bit saw_rst);
        n = 0;
        saw_rst = 1'b0;
        do begin
            @(negedge clk);
            n++;
            if (rst_pulse) saw_rst = 1'b1;
        end while (!irq && n < maxc);
        if (!irq) n = -1;
    endtask

    task automatic t_reset();
        chk("R1 ctrl after reset", int'(ctrl_rd), 0);
        chk("R1 rst_pulse after reset", int'(rst_pulse), 0);
        chk("R1 irq after reset", int'(irq), 0);
    endtask

    task automatic t_locked();
        wr(8'h2F);
        chk("R6 locked write ignored", int'(ctrl_rd), 8'h00);
        wr(8'h40);
        chk("R6 irq enable writable", int'(ctrl_rd), 8'h40);
        wr(8'h00);
        chk("R6 irq enable cleared", int'(ctrl_rd), 8'h00);
    endtask

    task automatic t_unlock_period();
        int n;
        wr(8'h18);
        chk("R5 window opens", int'(ctrl_rd), 8'h10);
        wr(8'h09);
        chk("R5 settings loaded", int'(ctrl_rd), 8'h09);
        wait_pulse(100, n);
        @(negedge clk);
        chk("R2 pulse one cycle wide", int'(rst_pulse), 0);
        wait_pulse(100, n);
        chk("R2 interval code 1", n + 1, 8);
        unlock(8'h28);
        chk("R5 code 8 loaded", int'(ctrl_rd), 8'h28);
        wait_pulse(3000, n);
        wait_pulse(3000, n);
        chk("R2 interval code 8", n, 1024);
    endtask

    task automatic t_reserved();
        int n;
        unlock(8'h2F);
        wait_pulse(5000, n);
        wait_pulse(5000, n);
        chk("R9 code 15 acts as 9", n, 2048);
        unlock(8'h00);
        chk("R9 disabled again", int'(ctrl_rd), 8'h00);
    endtask

    task automatic t_window();
        wr(8'h18);
        idle(3);
        chk("R7 window still open", int'(ctrl_rd[4]), 1);
        idle(1);
        chk("R7 window expired", int'(ctrl_rd[4]), 0);
        wr(8'h09);
        chk("R7 late write ignored", int'(ctrl_rd), 8'h00);
        wr(8'h18);
        idle(3);
        wr(8'h09);
        chk("R7 last slot accepted", int'(ctrl_rd), 8'h09);
        unlock(8'h00);
    endtask

    task automatic t_irq();
        int n;
        bit sr;
        wr(8'h40);
        wait_irq(20, n, sr);
        chk("R3 irq raised", int'(irq), 1);
        chk("R3 no reset in irq mode", int'(sr), 0);
        chk("R3 flag and enable", int'(ctrl_rd), 8'hC0);
        wr(8'hC0);
        chk("R3 flag cleared by write", int'(ctrl_rd), 8'h40);
        wr(8'h80);
        chk("R3 irq mode off", int'(ctrl_rd), 8'h00);
    endtask

    task automatic t_combo();
        int n;
        bit sr;
        unlock(8'h08);
        wr(8'h48);
        wait_irq(20, n, sr);
        chk("R4 first timeout no reset", int'(sr), 0);
        chk("R4 enable dropped", int'(ctrl_rd), 8'h88);
        wr(8'hC8);
        chk("R4 rearmed", int'(ctrl_rd), 8'h48);
        wait_irq(20, n, sr);
        chk("R4 rearmed gives irq", int'(irq), 1);
        chk("R4 rearmed no reset", int'(sr), 0);
        wr(8'h80);
        chk("R4 flag cleared", int'(ctrl_rd), 8'h08);
        wait_pulse(20, n);
        chk("R4 unarmed timeout resets", int'(n > 0), 1);
        chk("R4 no irq with reset", int'(irq), 0);
        unlock(8'h00);
    endtask

    task automatic t_restart_tick();
        int n;
        unlock(8'h0A);
        wait_pulse(100, n);
        idle(9);
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        wait_pulse(100, n);
        chk("R10 full period after restart", n, 16);
        chk("R10 settings kept", int'(ctrl_rd), 8'h0A);
        tick = 1'b0;
        idle(20);
        chk("R11 no timeout without tick", int'(rst_pulse), 0);
        tick = 1'b1;
        wait_pulse(100, n);
        chk("R11 interval stretched by idle", n + 20, 36);
        unlock(8'h00);
    endtask

    task automatic t_safety();
        int n;
        safety_on = 1'b1;
        #0;
        chk("R8 enable reads one", int'(ctrl_rd), 8'h08);
        wait_pulse(100, n);
        wait_pulse(100, n);
        chk("R8 forced reset interval", n, 4);
        wr(8'h01);
        chk("R8 code locked", int'(ctrl_rd), 8'h08);
        unlock(8'h01);
        chk("R8 code via unlock", int'(ctrl_rd), 8'h09);
        wait_pulse(100, n);
        wait_pulse(100, n);
        chk("R8 new interval", n, 8);
        safety_on = 1'b0;
        #0;
        chk("R8 stored enable off", int'(ctrl_rd), 8'h01);
        wait_pulse(40, n);
        chk("R8 no pulses when released", n, -1);
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_locked();
        t_unlock_period();
        t_reserved();
        t_window();
        t_irq();
        t_combo();
        t_restart_tick();
        t_safety();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule